// File: doc/BRIEF.md
# Multi-Source System Reset Controller

This block merges every reset cause of a small controller into one internal active-high reset, `sys_rst`, which goes to the CPU and its peripherals. It also drives `pin_pull`, the enable of an open-drain pull-down on the external reset pad. There are five causes: a rising supply-good level (power-on), the external pad held low by outside logic, a single-ended-zero (SE0) that persists on the upstream USB line pair, a watchdog timeout strobe, and a low-voltage trip level. The watchdog and low-voltage causes each have a static enable. A static option picks a short or a long power-on hold. A small bus write port produces the watchdog clear pulse.

The sequencing is done by a three-state machine. `ST_POR_WAIT` is entered whenever `supply_ok` is low and counts out the power-on hold. `ST_HOLD` is entered while any other cause is active. `ST_RUN` is the normal operating state. The transitions are as follows:
- POR_WAIT goes to RUN when the count expires and no cause is active.
- POR_WAIT goes to HOLD when the count expires and some cause is still active.
- RUN goes to HOLD when any cause becomes active.
- HOLD goes to RUN when every cause is idle.
- Any state goes to POR_WAIT, asynchronously, when `supply_ok` falls.

A sticky cause vector records which sources have fired. It is cleared by a strobe.

Top module: `sysrst_hub`

## Requirements
- R1: After `supply_ok` rises, `sys_rst` stays high for exactly 224 clock edges when `long_por` = 0, or exactly 4064 edges when `long_por` = 1.
- R2: If any other cause is active when the power-on count expires, `sys_rst` stays high until every cause has ended.
- R3: Power-on never raises `pin_pull`. Only the watchdog and low-voltage causes raise it.
- R4: While `supply_ok` is low, `sys_rst` is high and the power-on detector is re-armed. Each new rise starts a fresh power-on hold.
- R5: With `usb_tick` counting `OVS` = 4 samples per bit, an SE0 (`usb_dp` = 0 and `usb_dm` = 0) seen on 16 consecutive ticks asserts `sys_rst` and sets cause bit 2. A shorter SE0 clears the persistence count and has no effect.
- R6: A bus write with `bus_addr` = 0x1FF0 and `bus_wdata[0]` = 0 produces a `wdt_clear` pulse of one cycle after the write edge. Writing 1 to that bit, or writing to any other address, produces no pulse.
- R7: The watchdog clear bit is write-only: `bus_rdata` always reads 0.
- R8: An enabled watchdog timeout asserts `sys_rst` and drives `pin_pull` for exactly one cycle. When `wdt_en` = 0 the timeout is ignored.
- R9: An enabled low-voltage trip drives `pin_pull` for exactly one cycle and holds `sys_rst` for as long as the trip stays high. When `lvr_en` = 0 the trip is ignored.
- R10: A low on `rst_pad_in` passes through a two-flop synchroniser and holds `sys_rst` for as long as the pad stays low. `sys_rst` releases on the third edge after the pad returns high.
- R11: The cause vector uses bit 0 for power-on, bit 1 for the pad, bit 2 for USB, bit 3 for the watchdog and bit 4 for low voltage. It reads 5'b00001 after a power-on. Bits are sticky and are cleared by `cause_clr`, and a source that fires in the same cycle wins over the clear.
- R12: `sys_rst` is a register output. It falls only on an edge at which all causes were idle and the power-on count had finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| supply_ok | input | 1 | Supply-good level from the analog comparator; low acts as an asynchronous reset of the block |
| long_por | input | 1 | Static option: 0 selects the short power-on hold, 1 selects the long one |
| rst_pad_in | input | 1 | Sensed level of the external reset pad; asynchronous, active low |
| usb_dp | input | 1 | Upstream USB D+ receiver level |
| usb_dm | input | 1 | Upstream USB D- receiver level |
| usb_tick | input | 1 | Line sample strobe, OVS per bit time |
| wdt_timeout | input | 1 | Watchdog timeout strobe |
| wdt_en | input | 1 | Static watchdog enable option |
| lvr_trip | input | 1 | Low-voltage trip level |
| lvr_en | input | 1 | Static low-voltage reset enable option |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | 13 | Bus address |
| bus_wdata | input | 8 | Bus write data |
| cause_clr | input | 1 | Clears the sticky cause vector |
| sys_rst | output | 1 | Internal reset, active high, registered |
| pin_pull | output | 1 | Pull-down enable for the external reset pad |
| wdt_clear | output | 1 | One-cycle restart pulse to the watchdog chain |
| bus_rdata | output | 8 | Read data of the watchdog clear register, always 0 |
| rst_cause | output | 5 | Sticky per-source reset flags |

## Verification
The hardest case to reach from the ports is an SE0 that ends exactly at the persistence boundary. One tick too few must leave no trace, and exactly enough must give a single reset cycle and a flag. The bench therefore sweeps every SE0 length from 1 to 20 ticks. For each length it records whether `sys_rst` ever rose and reads cause bit 2, then compares both with the arithmetic rule that the length must be at least 16. The second hard case is a cause that is still active when the power-on count expires. To reach it, the bench holds the pad low across a whole power-on hold and releases it well after expiry.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;

    typedef enum logic [1:0] {
        ST_POR_WAIT = 2'd0,
        ST_HOLD     = 2'd1,
        ST_RUN      = 2'd2
    } rst_state_t;

    localparam int CAUSE_W   = 5;
    localparam int CAUSE_POR = 0;
    localparam int CAUSE_PAD = 1;
    localparam int CAUSE_USB = 2;
    localparam int CAUSE_WDT = 3;
    localparam int CAUSE_LVR = 4;

endpackage

// File: rtl/sysrst_sync.sv
module sysrst_sync #(
    parameter int STAGES    = 2,
    parameter bit IDLE_LVL  = 1'b1
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge arst_n) begin
                    if (!arst_n) chain[0] <= IDLE_LVL;
                    else         chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge arst_n) begin
                    if (!arst_n) chain[i] <= IDLE_LVL;
                    else         chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/sysrst_se0_det.sv
module sysrst_se0_det #(
    parameter int OVS      = 4,
    parameter int MIN_BITS = 4
) (
    input  logic clk,
    input  logic arst_n,
    input  logic tick,
    input  logic dp,
    input  logic dm,
    output logic active
);

    localparam int THR = OVS * MIN_BITS;
    localparam int CW  = $clog2(THR + 1);
    localparam logic [CW-1:0] THR_V = CW'(THR);

    logic [CW-1:0] run_cnt;
    logic          se0;

    assign se0 = ~dp & ~dm;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            run_cnt <= '0;
        end else if (tick) begin
            if (!se0)                run_cnt <= '0;
            else if (run_cnt != THR_V) run_cnt <= run_cnt + 1'b1;
        end
    end

    assign active = (run_cnt == THR_V);

    // R5: detection only comes up after an SE0 sample on a tick
    p_se0_needs_line_r5: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(active) |-> $past(se0 && tick));

endmodule

// File: rtl/sysrst_wdclr.sv
module sysrst_wdclr #(
    parameter int              AW       = 13,
    parameter int              DW       = 8,
    parameter logic [AW-1:0]   CLR_ADDR = 13'h1FF0,
    parameter int              CLR_BIT  = 0
) (
    input  logic          clk,
    input  logic          arst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          clr_pulse,
    output logic [DW-1:0] rdata
);

    logic hit_zero;

    assign hit_zero = we && (addr == CLR_ADDR) && !wdata[CLR_BIT];

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) clr_pulse <= 1'b0;
        else         clr_pulse <= hit_zero;
    end

    assign rdata = '0;

    // R6: a clear pulse follows only a zero written to the clear address
    p_clear_from_write_r6: assert property (@(posedge clk) disable iff (!arst_n)
        clr_pulse |-> $past(we && addr == CLR_ADDR && wdata[CLR_BIT] == 1'b0));

endmodule

// File: rtl/sysrst_hub.sv
module sysrst_hub
    import sysrst_pkg::*;
#(
    parameter int POR_SHORT = 224,
    parameter int POR_LONG  = 4064,
    parameter int OVS       = 4,
    parameter int SE0_BITS  = 4,
    parameter int AW        = 13,
    parameter int DW        = 8
) (
    input  logic               clk,
    input  logic               supply_ok,
    input  logic               long_por,
    input  logic               rst_pad_in,
    input  logic               usb_dp,
    input  logic               usb_dm,
    input  logic               usb_tick,
    input  logic               wdt_timeout,
    input  logic               wdt_en,
    input  logic               lvr_trip,
    input  logic               lvr_en,
    input  logic               bus_we,
    input  logic [AW-1:0]      bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    input  logic               cause_clr,
    output logic               sys_rst,
    output logic               pin_pull,
    output logic               wdt_clear,
    output logic [DW-1:0]      bus_rdata,
    output logic [CAUSE_W-1:0] rst_cause
);

    localparam int CW = $clog2(POR_LONG + 1);
    localparam logic [CW-1:0] LAST_SHORT = CW'(POR_SHORT - 1);
    localparam logic [CW-1:0] LAST_LONG  = CW'(POR_LONG - 1);

    rst_state_t    state, state_nx;
    logic [CW-1:0] por_cnt;
    logic          por_done;
    logic          pad_sync, pad_low;
    logic          usb_active;
    logic          wdt_act, wdt_prev, wdt_rise;
    logic          lvr_act, lvr_prev, lvr_rise;
    logic          any_src;

    sysrst_sync #(.STAGES(2), .IDLE_LVL(1'b1)) u_pad_sync (
        .clk     (clk),
        .arst_n  (supply_ok),
        .d_async (rst_pad_in),
        .q_sync  (pad_sync)
    );

    sysrst_se0_det #(.OVS(OVS), .MIN_BITS(SE0_BITS)) u_se0 (
        .clk    (clk),
        .arst_n (supply_ok),
        .tick   (usb_tick),
        .dp     (usb_dp),
        .dm     (usb_dm),
        .active (usb_active)
    );

    sysrst_wdclr #(.AW(AW), .DW(DW)) u_wdclr (
        .clk       (clk),
        .arst_n    (supply_ok),
        .we        (bus_we),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .clr_pulse (wdt_clear),
        .rdata     (bus_rdata)
    );

    assign pad_low  = ~pad_sync;
    assign wdt_act  = wdt_en & wdt_timeout;
    assign lvr_act  = lvr_en & lvr_trip;
    assign wdt_rise = wdt_act & ~wdt_prev;
    assign lvr_rise = lvr_act & ~lvr_prev;
    assign any_src  = pad_low | usb_active | wdt_act | lvr_act;
    assign por_done = (por_cnt == (long_por ? LAST_LONG : LAST_SHORT));

    // state register and power-on counter
    always_ff @(posedge clk or negedge supply_ok) begin
        if (!supply_ok) begin
            state   <= ST_POR_WAIT;
            por_cnt <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_POR_WAIT && !por_done) por_cnt <= por_cnt + 1'b1;
        end
    end

    // next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_POR_WAIT: if (por_done) state_nx = any_src ? ST_HOLD : ST_RUN;
            ST_HOLD:     if (!any_src) state_nx = ST_RUN;
            ST_RUN:      if (any_src)  state_nx = ST_HOLD;
            default:     state_nx = ST_POR_WAIT;
        endcase
    end

    // registered outputs
    always_ff @(posedge clk or negedge supply_ok) begin
        if (!supply_ok) begin
            sys_rst   <= 1'b1;
            pin_pull  <= 1'b0;
            wdt_prev  <= 1'b0;
            lvr_prev  <= 1'b0;
            rst_cause <= CAUSE_W'(1) << CAUSE_POR;
        end else begin
            sys_rst   <= (state_nx != ST_RUN);
            pin_pull  <= wdt_rise | lvr_rise;
            wdt_prev  <= wdt_act;
            lvr_prev  <= lvr_act;
            rst_cause <= (cause_clr ? '0 : rst_cause)
                       | (CAUSE_W'(pad_low)    << CAUSE_PAD)
                       | (CAUSE_W'(usb_active) << CAUSE_USB)
                       | (CAUSE_W'(wdt_act)    << CAUSE_WDT)
                       | (CAUSE_W'(lvr_act)    << CAUSE_LVR);
        end
    end

    // R1: the power-on count keeps the internal reset asserted
    p_por_holds_rst_r1: assert property (@(posedge clk) disable iff (!supply_ok)
        (state == ST_POR_WAIT) |-> sys_rst);

    // R3: the pad is pulled only after a watchdog or low-voltage edge
    p_pull_source_r3: assert property (@(posedge clk) disable iff (!supply_ok)
        pin_pull |-> $past(wdt_rise || lvr_rise));

    // R12: release only after an idle cycle outside the power-on count
    p_release_idle_r12: assert property (@(posedge clk) disable iff (!supply_ok)
        $fell(sys_rst) |-> $past(!any_src && (state != ST_POR_WAIT || por_done)));

    // R2: an active cause never lets the state machine run
    p_src_blocks_run_r2: assert property (@(posedge clk) disable iff (!supply_ok)
        (any_src && state != ST_RUN) |=> (state != ST_RUN));

endmodule

// File: tb/sim_sysrst_hub.sv
module sim_sysrst_hub;

    logic        clk = 1'b0;
    logic        supply_ok = 1'b0;
    logic        long_por = 1'b0;
    logic        rst_pad_in = 1'b1;
    logic        usb_dp = 1'b1;
    logic        usb_dm = 1'b0;
    logic        usb_tick = 1'b1;
    logic        wdt_timeout = 1'b0;
    logic        wdt_en = 1'b1;
    logic        lvr_trip = 1'b0;
    logic        lvr_en = 1'b1;
    logic        bus_we = 1'b0;
    logic [12:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        cause_clr = 1'b0;
    logic        sys_rst, pin_pull, wdt_clear;
    logic [7:0]  bus_rdata;
    logic [4:0]  rst_cause;

    int n_tests = 0;
    int n_fail  = 0;
    int pull_cnt = 0;
    int rst_seen = 0;
    int clr_cnt  = 0;

    always #5 clk = ~clk;

    sysrst_hub u0 (
        .clk(clk), .supply_ok(supply_ok), .long_por(long_por),
        .rst_pad_in(rst_pad_in), .usb_dp(usb_dp), .usb_dm(usb_dm),
        .usb_tick(usb_tick), .wdt_timeout(wdt_timeout), .wdt_en(wdt_en),
        .lvr_trip(lvr_trip), .lvr_en(lvr_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cause_clr(cause_clr),
        .sys_rst(sys_rst), .pin_pull(pin_pull), .wdt_clear(wdt_clear),
        .bus_rdata(bus_rdata), .rst_cause(rst_cause)
    );

    always @(posedge clk) begin
        if (pin_pull)  pull_cnt++;
        if (sys_rst)   rst_seen++;
        if (wdt_clear) clr_cnt++;
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_causes();
        cause_clr = 1'b1;
        step(1);
        cause_clr = 1'b0;
    endtask

    task automatic power_cycle(input logic sel, input int lim);
        supply_ok = 1'b0;
        long_por  = sel;
        step(2);
        chk("R4 rst while supply low", sys_rst, 1);
        pull_cnt = 0;
        supply_ok = 1'b1;
        step(lim - 1);
        chk("R1 still held at last edge-1", sys_rst, 1);
        step(1);
        chk("R1 released at limit", sys_rst, 0);
        chk("R3 no pull on power-on", pull_cnt, 0);
        chk("R11 cause after power-on", rst_cause, 5'b00001);
    endtask

    initial begin
        step(1);
        // R1 / R4: both delays, second one only after a fresh supply fall
        power_cycle(1'b0, 224);
        chk("R7 rdata zero", bus_rdata, 0);
        power_cycle(1'b1, 4064);
        power_cycle(1'b0, 224);
        clear_causes();
        chk("R11 clear", rst_cause, 0);

        // R6 / R7: watchdog clear writes
        clr_cnt = 0;
        bus_we = 1'b1; bus_addr = 13'h1FF0; bus_wdata = 8'hFE;
        step(1);
        bus_we = 1'b0;
        chk("R6 clear pulse", wdt_clear, 1);
        step(1);
        chk("R6 single pulse", wdt_clear, 0);
        bus_we = 1'b1; bus_wdata = 8'h01;
        step(1);
        bus_we = 1'b0;
        step(1);
        bus_we = 1'b1; bus_addr = 13'h1FF1; bus_wdata = 8'h00;
        step(1);
        bus_we = 1'b0;
        step(1);
        chk("R6 only one clear overall", clr_cnt, 1);
        chk("R7 rdata after write of 1", bus_rdata, 0);

        // R8: watchdog timeout
        pull_cnt = 0;
        wdt_timeout = 1'b1;
        step(1);
        wdt_timeout = 1'b0;
        chk("R8 pull on timeout", pin_pull, 1);
        chk("R8 rst on timeout", sys_rst, 1);
        step(1);
        chk("R8 pull one cycle", pin_pull, 0);
        chk("R12 rst released after idle", sys_rst, 0);
        chk("R11 wdt cause", rst_cause, 5'b01000);
        clear_causes();
        wdt_en = 1'b0; pull_cnt = 0; rst_seen = 0;
        wdt_timeout = 1'b1;
        step(1);
        wdt_timeout = 1'b0;
        step(3);
        chk("R8 disabled no pull", pull_cnt, 0);
        chk("R8 disabled no rst", rst_seen, 0);
        chk("R8 disabled no cause", rst_cause, 0);
        wdt_en = 1'b1;

        // R9: low-voltage trip
        pull_cnt = 0;
        lvr_trip = 1'b1;
        step(1);
        chk("R9 pull on trip", pin_pull, 1);
        step(1);
        chk("R9 pull one cycle", pin_pull, 0);
        chk("R9 rst held", sys_rst, 1);
        step(6);
        chk("R9 rst held long", sys_rst, 1);
        chk("R9 one pull total", pull_cnt, 1);
        lvr_trip = 1'b0;
        step(1);
        chk("R9 rst released", sys_rst, 0);
        chk("R11 lvr cause", rst_cause, 5'b10000);
        clear_causes();
        lvr_en = 1'b0; rst_seen = 0; pull_cnt = 0;
        lvr_trip = 1'b1;
        step(4);
        lvr_trip = 1'b0;
        step(2);
        chk("R9 disabled no rst", rst_seen, 0);
        chk("R9 disabled no pull", pull_cnt, 0);
        lvr_en = 1'b1;

        // R10: external pad through the synchroniser
        rst_pad_in = 1'b0;
        step(2);
        chk("R10 not yet (sync)", sys_rst, 0);
        step(1);
        chk("R10 rst from pad", sys_rst, 1);
        step(10);
        chk("R10 held while pad low", sys_rst, 1);
        rst_pad_in = 1'b1;
        step(2);
        chk("R10 held during sync", sys_rst, 1);
        step(1);
        chk("R10 released", sys_rst, 0);
        chk("R11 pad cause", rst_cause, 5'b00010);
        clear_causes();

        // R5: SE0 length sweep
        for (int len = 1; len <= 20; len++) begin
            rst_seen = 0;
            usb_dp = 1'b0; usb_dm = 1'b0;
            step(len);
            usb_dp = 1'b1;
            step(4);
            chk($sformatf("R5 rst for SE0 len %0d", len), rst_seen != 0, len >= 16);
            chk($sformatf("R5 flag for SE0 len %0d", len), rst_cause[2], len >= 16);
            chk($sformatf("R5 rst idle after len %0d", len), sys_rst, 0);
            clear_causes();
            step(1);
        end

        // R2: cause active across power-on expiry
        supply_ok = 1'b0;
        long_por = 1'b0;
        rst_pad_in = 1'b0;
        step(2);
        pull_cnt = 0;
        supply_ok = 1'b1;
        step(224 + 20);
        chk("R2 held past expiry", sys_rst, 1);
        rst_pad_in = 1'b1;
        step(2);
        chk("R2 still held in sync", sys_rst, 1);
        step(1);
        chk("R2 released after source", sys_rst, 0);
        chk("R3 no pull", pull_cnt, 0);
        chk("R11 por and pad causes", rst_cause, 5'b00011);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule